// File: doc/BRIEF.md
# PWM Comparison Unit with Periodic Update

This block watches the counter of a reference PWM channel and raises a one-cycle compare-match event when that counter reaches a programmed comparison value. A mode bit selects whether the match is taken on the up-counting or the down-counting phase, which supports center-aligned operation. A separate enable bit gates matching.

The comparison value, the mode bits and the update period are held twice. Software writes a shadow copy. The active copy, which the comparator uses, is reloaded from the shadow only when the update-period counter expires. That counter is separate from the reference channel's own period counter and advances on each period-end strobe. A new comparison value is accepted into the shadow only when a mode write follows it. Software can therefore change the value and the mode as one coherent pair while the channel runs.

Match and update events set sticky status flags. Each flag can drive the interrupt output when its mask bit is enabled.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After reset, match_o, update_o and irq_o are low. The status register (address 4), the mask register (address 5), the active value (address 6) and the active mode (address 7) all read as zero.
- R2: The update counter advances by one on each ref_period_end strobe. When the counter equals the active update period P, that strobe raises update_o for the same cycle and the counter wraps to zero, so an update occurs every P+1 strobes.
- R3: The active value (read at address 6) and the active mode (read at address 7) change only on an update event. At that event they take the shadow contents.
- R4: A value write (address 0, bits [CNT_W-1:0]) enters the shadow only when a mode write follows it. A value write with no mode write after it is never committed, even across update events.
- R5: A mode write (address 1) stores bit 0 = match enable, bit 1 = direction select and bits [8+UPR_W-1:8] = update period into the shadow. A new update period first governs the count after the next update event.
- R6: With matching enabled, match_o pulses for one cycle on the first cycle in which ref_cnt equals the active value and ref_down equals the direction select (0 = up-counting, 1 = down-counting). It stays low while that condition persists and while the direction differs.
- R7: While the active enable bit is clear, no match pulse and no match flag are produced, but update events continue.
- R8: Status bit 0 records a match and bit 1 records an update. Reading address 4 returns both flags and clears them.
- R9: Writing ones to address 2 sets mask bits and writing ones to address 3 clears them. The mask reads back at address 5. irq_o is high exactly when a status flag and its mask bit are both set.
- R10: When an event occurs in the same cycle as a status read, its flag is set after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe (reads of address 4 clear the status) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational from rd_addr |
| ref_cnt | input | CNT_W | Counter value of the reference channel |
| ref_down | input | 1 | Reference counter is counting down |
| ref_period_end | input | 1 | One-cycle strobe at the end of each reference period |
| match_o | output | 1 | Compare-match event pulse |
| update_o | output | 1 | Shadow-to-active update event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are a staged value write that is left unpaired while update events pass, and an event that lands in the very cycle in which the status register is read. The stimulus reaches the first by writing only the value register and then running a full update period before the mode write. It checks the active value before and after the later pairing. The second case is built with a single composite cycle task that drives a read strobe, a period-end strobe or a matching counter value together on the same clock edge. A follow-up read then shows which of the two won. The double-buffered update period is confirmed by counting how many strobes separate successive update pulses before and after the period change.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  typedef enum logic [2:0] {
    A_VAL_UPD  = 3'd0,
    A_MODE_UPD = 3'd1,
    A_IRQ_SET  = 3'd2,
    A_IRQ_CLR  = 3'd3,
    A_IRQ_STAT = 3'd4,
    A_IRQ_MASK = 3'd5,
    A_VAL_ACT  = 3'd6,
    A_MODE_ACT = 3'd7
  } reg_addr_e;

  localparam int MODE_EN_BIT   = 0;
  localparam int MODE_DIR_BIT  = 1;
  localparam int MODE_UPR_LSB  = 8;
  localparam int EV_MATCH      = 0;
  localparam int EV_UPDATE     = 1;
  localparam int EV_N          = 2;

  // update period has elapsed when the strobe count reaches the limit
  function automatic logic upr_expired(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == lim;
  endfunction

  // comparator hit: value equal and counting phase as selected
  function automatic logic cmp_hit(input logic [31:0] cnt, input logic [31:0] val,
                                   input logic dir_now, input logic dir_sel);
    return (cnt == val) && (dir_now == dir_sel);
  endfunction

endpackage

// File: rtl/pwm_cmp_upd_timer.sv
module pwm_cmp_upd_timer
  import pwm_cmp_pkg::*;
#(
  parameter int UPR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_end,
  input  logic [UPR_W-1:0] upr_lim,
  output logic             upd_evt,
  output logic [UPR_W-1:0] upr_cnt
);

  assign upd_evt = period_end && upr_expired(32'(upr_cnt), 32'(upr_lim));

  always_ff @(posedge clk) begin
    if (!rst_n)          upr_cnt <= '0;
    else if (upd_evt)    upr_cnt <= '0;
    else if (period_end) upr_cnt <= upr_cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    upr_cnt <= upr_lim); // R2
  AST_UPD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (upr_cnt == '0)); // R2
  AST_UPD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(upr_cnt)); // R2

endmodule

// File: rtl/pwm_cmp_match.sv
module pwm_cmp_match
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir_sel,
  input  logic [CNT_W-1:0] act_val,
  input  logic [CNT_W-1:0] ref_cnt,
  input  logic             ref_down,
  output logic             match_evt
);

  logic hit, hit_q;

  assign hit       = en && cmp_hit(32'(ref_cnt), 32'(act_val), ref_down, dir_sel);
  assign match_evt = hit && !hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt); // R6
  AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> (ref_cnt == act_val && ref_down == dir_sel)); // R6
  AST_MATCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !match_evt); // R7

endmodule

// File: rtl/pwm_cmp_irq.sv
module pwm_cmp_irq
  import pwm_cmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev,
  input  logic            mask_set,
  input  logic            mask_clr,
  input  logic [EV_N-1:0] mask_bits,
  input  logic            stat_rd,
  output logic [EV_N-1:0] stat,
  output logic [EV_N-1:0] mask,
  output logic            irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      // a new event overrides the read-clear of the same cycle
      stat <= (stat & ~{EV_N{stat_rd}}) | ev;
      if (mask_set)      mask <= mask | mask_bits;
      else if (mask_clr) mask <= mask & ~mask_bits;
    end
  end

  assign irq = |(stat & mask);

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_MATCH] |=> stat[EV_MATCH]); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ev == '0) |=> (stat == '0)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[EV_UPDATE] && !stat_rd) |=> stat[EV_UPDATE]); // R8
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R9

endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int UPR_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  ref_cnt,
  input  logic              ref_down,
  input  logic              ref_period_end,
  output logic              match_o,
  output logic              update_o,
  output logic              irq_o
);

  localparam int UPR_MSB = MODE_UPR_LSB + UPR_W - 1;

  reg_addr_e wa, ra;
  logic wr_val, wr_mode, mask_set, mask_clr, stat_rd;

  // staged value waits for a mode write before entering the shadow
  logic [CNT_W-1:0] stg_val;
  logic             stg_pend;
  logic [CNT_W-1:0] shd_val, act_val;
  logic             shd_en, act_en, shd_dir, act_dir;
  logic [UPR_W-1:0] shd_upr, act_upr, upr_cnt;
  logic             upd_evt, match_evt;
  logic [EV_N-1:0]  ev, stat, mask;
  logic             unused_wdata;

  assign wa       = reg_addr_e'(wr_addr);
  assign ra       = reg_addr_e'(rd_addr);
  assign wr_val   = wr_en && (wa == A_VAL_UPD);
  assign wr_mode  = wr_en && (wa == A_MODE_UPD);
  assign mask_set = wr_en && (wa == A_IRQ_SET);
  assign mask_clr = wr_en && (wa == A_IRQ_CLR);
  assign stat_rd  = rd_en && (ra == A_IRQ_STAT);
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_val  <= '0;
      stg_pend <= 1'b0;
      shd_val  <= '0;
      shd_en   <= 1'b0;
      shd_dir  <= 1'b0;
      shd_upr  <= '0;
    end else if (wr_val) begin
      stg_val  <= wr_data[CNT_W-1:0];
      stg_pend <= 1'b1;
    end else if (wr_mode) begin
      shd_en  <= wr_data[MODE_EN_BIT];
      shd_dir <= wr_data[MODE_DIR_BIT];
      shd_upr <= wr_data[UPR_MSB:MODE_UPR_LSB];
      if (stg_pend) begin
        shd_val  <= stg_val;
        stg_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_val <= '0;
      act_en  <= 1'b0;
      act_dir <= 1'b0;
      act_upr <= '0;
    end else if (upd_evt) begin
      act_val <= shd_val;
      act_en  <= shd_en;
      act_dir <= shd_dir;
      act_upr <= shd_upr;
    end
  end

  pwm_cmp_upd_timer #(.UPR_W(UPR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_end(ref_period_end),
    .upr_lim(act_upr), .upd_evt(upd_evt), .upr_cnt(upr_cnt)
  );

  pwm_cmp_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .en(act_en), .dir_sel(act_dir),
    .act_val(act_val), .ref_cnt(ref_cnt), .ref_down(ref_down),
    .match_evt(match_evt)
  );

  assign ev[EV_MATCH]  = match_evt;
  assign ev[EV_UPDATE] = upd_evt;

  pwm_cmp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .mask_set(mask_set),
    .mask_clr(mask_clr), .mask_bits(wr_data[EV_N-1:0]),
    .stat_rd(stat_rd), .stat(stat), .mask(mask), .irq(irq_o)
  );

  always_comb begin
    rd_data = '0;
    case (ra)
      A_IRQ_STAT: rd_data[EV_N-1:0] = stat;
      A_IRQ_MASK: rd_data[EV_N-1:0] = mask;
      A_VAL_ACT:  rd_data[CNT_W-1:0] = act_val;
      A_MODE_ACT: begin
        rd_data[MODE_EN_BIT]           = act_en;
        rd_data[MODE_DIR_BIT]          = act_dir;
        rd_data[UPR_MSB:MODE_UPR_LSB]  = act_upr;
      end
      default: rd_data = '0;
    endcase
  end

  assign match_o  = match_evt;
  assign update_o = upd_evt;

  AST_ACTIVE_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_val != $past(act_val)) |-> $past(upd_evt)); // R3
  AST_VALUE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_val != $past(shd_val)) |-> $past(wr_mode)); // R4
  AST_UPR_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_upr != $past(act_upr)) |-> $past(upd_evt)); // R5

endmodule

// File: tb/pwm_cmp_unit_bench.sv
module pwm_cmp_unit_bench;
  localparam int CW = 16;
  localparam int UW = 4;
  localparam int DW = 32;
  localparam logic [CW-1:0] IDLE = 16'h7FFF;
  // register addresses as given in the requirements
  localparam logic [2:0] AD_VAL = 3'd0, AD_MODE = 3'd1, AD_SET = 3'd2, AD_CLR = 3'd3,
                         AD_STAT = 3'd4, AD_MASK = 3'd5, AD_AVAL = 3'd6, AD_AMODE = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ref_down = 1'b0, ref_pe = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [CW-1:0] ref_cnt = IDLE;
  logic match_o, update_o, irq_o;

  always #10 clk = ~clk;

  pwm_cmp_unit #(.CNT_W(CW), .UPR_W(UW), .DATA_W(DW)) u_pwm_cmp_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ref_cnt(ref_cnt),
    .ref_down(ref_down), .ref_period_end(ref_pe), .match_o(match_o),
    .update_o(update_o), .irq_o(irq_o)
  );

  typedef struct { int kind; int cnt; string req; } exp_t;  // kind 0 match, 1 update
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] mode_word(bit en, bit dn, int upr);
    return DW'(upr) << 8 | DW'(dn) << 1 | DW'(en);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, int cnt, string req);
    exp_q.push_back('{kind, cnt, req});
  endtask

  task automatic observe(int kind, int cnt);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event actual kind=%0d cnt=%0d expected none",
               kind == 0 ? "R6" : "R2", kind, cnt);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || (kind == 0 && e.cnt != cnt)) begin
        errors++;
        $display("FAIL %s actual kind=%0d cnt=%0d expected kind=%0d cnt=%0d",
                 e.req, kind, cnt, e.kind, e.cnt);
      end
    end
  endtask

  // monitor: samples mid-cycle while the driver holds its inputs
  initial forever begin
    @(negedge clk); #5;
    if (rst_n && !done) begin
      if (match_o)  observe(0, int'(ref_cnt));
      if (update_o) observe(1, int'(ref_cnt));
    end
  end

  task automatic cyc(logic [CW-1:0] c, logic dn, logic pe, logic we, logic [2:0] wa,
                     logic [DW-1:0] wd, logic re, logic [2:0] ra, output logic [DW-1:0] rd);
    @(negedge clk);
    ref_cnt = c; ref_down = dn; ref_pe = pe;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    #1 rd = rd_data;
    @(posedge clk); #1;
    ref_cnt = IDLE; ref_down = 1'b0; ref_pe = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    logic [DW-1:0] x;
    cyc(IDLE, 1'b0, 1'b0, 1'b1, a, d, 1'b0, 3'd0, x);
  endtask
  task automatic rd(logic [2:0] a, output logic [DW-1:0] d);
    cyc(IDLE, 1'b0, 1'b0, 1'b0, 3'd0, '0, 1'b1, a, d);
  endtask
  task automatic pe();
    logic [DW-1:0] x;
    cyc(IDLE, 1'b0, 1'b1, 1'b0, 3'd0, '0, 1'b0, 3'd0, x);
  endtask
  task automatic drv(logic [CW-1:0] c, logic dn);
    logic [DW-1:0] x;
    cyc(c, dn, 1'b0, 1'b0, 3'd0, '0, 1'b0, 3'd0, x);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1 reset state
    chk("R1 match_o", DW'(match_o), 0);
    chk("R1 update_o", DW'(update_o), 0);
    chk("R1 irq_o", DW'(irq_o), 0);
    rd(AD_STAT, d); chk("R1 status", d, 0);
    rd(AD_MASK, d); chk("R1 mask", d, 0);
    rd(AD_AVAL, d); chk("R1 active value", d, 0);
    rd(AD_AMODE, d); chk("R1 active mode", d, 0);

    // R2 period 0: every strobe updates; R8 read clears
    expect_ev(1, 0, "R2 period 0"); pe();
    rd(AD_STAT, d); chk("R8 update flag", d, 2);
    rd(AD_STAT, d); chk("R8 cleared", d, 0);

    // R3 shadow then commit
    wr(AD_VAL, 100);
    wr(AD_MODE, mode_word(1, 0, 2));
    rd(AD_AVAL, d); chk("R3 active before update", d, 0);
    expect_ev(1, 0, "R3 commit"); pe();
    rd(AD_AVAL, d); chk("R3 active value", d, 100);
    rd(AD_AMODE, d); chk("R3 active mode", d, mode_word(1, 0, 2));

    // R2 period 2: update every third strobe
    pe(); pe();
    expect_ev(1, 0, "R2 period 2"); pe();

    // R6 up-count match, one pulse, direction filter
    drv(99, 0);
    expect_ev(0, 100, "R6 up match"); drv(100, 0);
    drv(100, 0);
    drv(101, 0);
    drv(100, 1);
    rd(AD_STAT, d); chk("R8 both flags", d, 3);
    rd(AD_STAT, d); chk("R8 cleared again", d, 0);

    // R4 value write without mode write is not committed
    wr(AD_VAL, 200);
    pe(); pe();
    expect_ev(1, 0, "R4 update"); pe();
    rd(AD_AVAL, d); chk("R4 unpaired value held", d, 100);
    expect_ev(0, 100, "R4 old value matches"); drv(100, 0);

    // R5 new period waits for the next update
    wr(AD_MODE, mode_word(1, 1, 0));
    pe(); pe();
    expect_ev(1, 0, "R5 old period"); pe();
    rd(AD_AVAL, d); chk("R4 paired value", d, 200);
    rd(AD_AMODE, d); chk("R5 active mode", d, mode_word(1, 1, 0));
    expect_ev(1, 0, "R5 new period"); pe();

    // R6 down-count match
    drv(200, 0);
    drv(201, 1);
    expect_ev(0, 200, "R6 down match"); drv(200, 1);

    // R9 mask
    rd(AD_STAT, d); chk("R8 flags", d, 3);
    wr(AD_SET, 1);
    chk("R9 irq off, flags clear", DW'(irq_o), 0);
    expect_ev(1, 0, "R9 update"); pe();
    chk("R9 update not enabled", DW'(irq_o), 0);
    expect_ev(0, 200, "R9 match"); drv(200, 1);
    chk("R9 match enabled", DW'(irq_o), 1);
    rd(AD_MASK, d); chk("R9 mask read", d, 1);
    wr(AD_CLR, 1);
    chk("R9 disabled", DW'(irq_o), 0);
    rd(AD_STAT, d); chk("R9 flags kept", d, 3);

    // R10 event with status read in the same cycle
    expect_ev(0, 200, "R10 match");
    cyc(200, 1'b1, 1'b0, 1'b0, 3'd0, '0, 1'b1, AD_STAT, d);
    chk("R10 read value", d, 0);
    rd(AD_STAT, d); chk("R10 match kept", d, 1);
    expect_ev(1, 0, "R10 update");
    cyc(IDLE, 1'b0, 1'b1, 1'b0, 3'd0, '0, 1'b1, AD_STAT, d);
    rd(AD_STAT, d); chk("R10 update kept", d, 2);

    // R7 disabled matching, updates continue
    wr(AD_MODE, mode_word(0, 1, 0));
    expect_ev(1, 0, "R7 update"); pe();
    drv(201, 1);
    drv(200, 1);
    rd(AD_STAT, d); chk("R7 no match flag", d, 2);
    rd(AD_AMODE, d); chk("R7 mode", d, mode_word(0, 1, 0));
    expect_ev(1, 0, "R7 update continues"); pe();

    repeat (2) @(negedge clk);
    chk("R2 R6 pending events", DW'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule